// File: doc/BRIEF.md
# Single-Error-Correcting Double-Error-Detecting Simple Dual-Port RAM

This block is an on-chip memory with one write port and one read port. Each has its own clock. Every 64-bit word is stored as a 72-bit codeword. The codeword is built as follows:

- Hamming check bits sit at the power-of-two positions 1, 2, 4, 8, 16, 32 and 64.
- The data bits fill the remaining positions from 3 to 71, in ascending order.
- Position 0 holds an overall parity bit over the other 71 bits.

On the read side the codeword goes through a decoder. A single flipped bit is repaired before it reaches the output. Two flipped bits are reported as uncorrectable. The condition of each word is shown on a 3-bit status output.

The read side has an output stage with an asynchronous clear. The stage is configured by parameters:

- `OUT_REG` inserts an extra output register. This gives a latency of two read clock edges instead of one.
- `STATUS_REG` makes the status output part of the clearable output stage. The alternative is a plain decoder output that the clear does not touch.

A test-only flip mask is XORed into the codeword as it is written. This lets a testbench plant 1-, 2- or 3-bit faults in the stored word.

Top module: `ecc_sdp_ram`

## Requirements
- R1: A word written with an all-zero flip mask reads back unchanged, with status 3'b000, at every address.
- R2: A flip mask with exactly one bit set, at any of the 72 codeword positions, still reads back the written data, with status 3'b011.
- R3: A flip mask with exactly two bits set, at any pair of positions, reads back with status 3'b101.
- R4: The status output only ever shows 3'b000, 3'b011 or 3'b101. No status is promised for three or more flipped bits.
- R5: With `OUT_REG`=1, read data appears two read clock edges after the address is presented. With `OUT_REG`=0 it appears after one edge. A status that is part of the output stage has the same latency as the data. An unregistered status appears after one edge.
- R6: While `outAclr` is high, `rdData` is zero in both output modes. In bypass mode it stays zero until the first read clock edge after the clear is released.
- R7: With `STATUS_REG`=1, `eccStatus` is 3'b000 while `outAclr` is high.
- R8: With `STATUS_REG`=0, asserting `outAclr` leaves `eccStatus` unchanged.
- R9: A read of the address being written on the same clock edge returns the previous content. The next read returns the new word.
- R10: While `wrEn` is low, `wrData` and `wrFlipMask` do not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock |
| wrEn | input | 1 | Store enable for the current write edge |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 64 | Data word to protect and store |
| wrFlipMask | input | 72 | Test-only mask XORed into the stored codeword |
| rdClk | input | 1 | Read port clock |
| rdAddr | input | ADDR_W | Read address |
| outAclr | input | 1 | Asynchronous clear of the read output stage |
| rdData | output | 64 | Corrected read data |
| eccStatus | output | 3 | 000 clean, 011 corrected, 101 uncorrectable |

## Verification
The bench builds two copies side by side with a 16-word array. One copy has `OUT_REG`=1 and `STATUS_REG`=1. The other has `OUT_REG`=0 and `STATUS_REG`=0. Both latency paths and both status behaviours under clear are therefore compared against the same stimulus.

The small configuration allows complete sweeps:

- a fault at each of the 72 codeword positions;
- every one of the 2556 two-bit fault pairs;
- a data pattern at every address.

The expected data is always the word that was written, so expected values come from simple bookkeeping in the bench and need no model of the decoder.

// File: rtl/ecc_sdp_pkg.sv
package ecc_sdp_pkg;

  localparam int DATA_W = 64;
  localparam int CODE_W = 72;
  localparam int SYN_W  = 7;

  localparam logic [2:0] ST_CLEAN = 3'b000;
  localparam logic [2:0] ST_FIXED = 3'b011;
  localparam logic [2:0] ST_FATAL = 3'b101;

  typedef struct packed {
    logic storeWord;
    logic holdZero;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [2:0]        status;
  } decodeOut_t;

  function automatic logic isPow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int j;
    logic par;
    cw = '0;
    j  = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isPow2(p)) begin
        cw[p] = d[j];
        j++;
      end
    end
    for (int i = 0; i < SYN_W; i++) begin
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> i) & 1) == 1) par ^= cw[p];
      end
      cw[1 << i] = par;
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic decodeOut_t eccDecode(input logic [CODE_W-1:0] cwIn);
    logic [CODE_W-1:0] cw;
    logic [SYN_W-1:0]  syn;
    logic              ov;
    decodeOut_t        res;
    int j;
    cw  = cwIn;
    syn = '0;
    for (int i = 0; i < SYN_W; i++) begin
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> i) & 1) == 1) syn[i] ^= cw[p];
      end
    end
    ov = ^cw;
    res.status = ST_CLEAN;
    if (ov) begin
      if (int'(syn) < CODE_W) begin
        cw[syn]    = ~cw[syn];
        res.status = ST_FIXED;
      end else begin
        res.status = ST_FATAL;
      end
    end else if (syn != '0) begin
      res.status = ST_FATAL;
    end
    res.data = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isPow2(p)) begin
        res.data[j] = cw[p];
        j++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_sdp_ctrl.sv
module ecc_sdp_ctrl
  import ecc_sdp_pkg::*;
(
  input  logic         rdClk,
  input  logic         wrEn,
  input  logic         outAclr,
  output ctrlStrobes_t strobes
);

  logic holdZeroQ;

  // Set at once by the clear, released by the first read edge afterwards.
  always_ff @(posedge rdClk or posedge outAclr) begin
    if (outAclr) holdZeroQ <= 1'b1;
    else         holdZeroQ <= 1'b0;
  end

  always_comb begin
    strobes.storeWord = wrEn;
    strobes.holdZero  = holdZeroQ;
  end

endmodule

// File: rtl/ecc_sdp_datapath.sv
module ecc_sdp_datapath
  import ecc_sdp_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit OUT_REG    = 1'b1,
  parameter bit STATUS_REG = 1'b1
) (
  input  logic              wrClk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] wrFlipMask,
  input  logic              rdClk,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              outAclr,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] decTap,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        eccStatus
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] memArr [DEPTH];
  logic [CODE_W-1:0] rawQ;
  decodeOut_t        dec;
  logic [DATA_W-1:0] latchData;
  logic [2:0]        latchStatus;

  always_ff @(posedge wrClk) begin
    if (strobes.storeWord) memArr[wrAddr] <= eccEncode(wrData) ^ wrFlipMask;
  end

  always_ff @(posedge rdClk) begin
    rawQ <= memArr[rdAddr];
  end

  always_comb begin
    dec         = eccDecode(rawQ);
    decTap      = dec.data;
    latchData   = strobes.holdZero ? '0 : dec.data;
    latchStatus = strobes.holdZero ? ST_CLEAN : dec.status;
  end

  generate
    if (OUT_REG) begin : g_outReg
      logic [DATA_W-1:0] dataQ;
      always_ff @(posedge rdClk or posedge outAclr) begin
        if (outAclr) dataQ <= '0;
        else         dataQ <= dec.data;
      end
      assign rdData = dataQ;

      if (STATUS_REG) begin : g_stReg
        logic [2:0] statQ;
        always_ff @(posedge rdClk or posedge outAclr) begin
          if (outAclr) statQ <= ST_CLEAN;
          else         statQ <= dec.status;
        end
        assign eccStatus = statQ;
      end else begin : g_stComb
        assign eccStatus = dec.status;
      end
    end else begin : g_outByp
      assign rdData = latchData;
      if (STATUS_REG) begin : g_stLatch
        assign eccStatus = latchStatus;
      end else begin : g_stComb
        assign eccStatus = dec.status;
      end
    end
  endgenerate

endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram
  import ecc_sdp_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit OUT_REG    = 1'b1,
  parameter bit STATUS_REG = 1'b1
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  input  logic [71:0]       wrFlipMask,
  input  logic              rdClk,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              outAclr,
  output logic [63:0]       rdData,
  output logic [2:0]        eccStatus
);

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] decTap;

  ecc_sdp_ctrl u_ctrl (
    .rdClk   (rdClk),
    .wrEn    (wrEn),
    .outAclr (outAclr),
    .strobes (strobes)
  );

  ecc_sdp_datapath #(
    .ADDR_W     (ADDR_W),
    .OUT_REG    (OUT_REG),
    .STATUS_REG (STATUS_REG)
  ) u_dp (
    .wrClk      (wrClk),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrFlipMask (wrFlipMask),
    .rdClk      (rdClk),
    .rdAddr     (rdAddr),
    .outAclr    (outAclr),
    .strobes    (strobes),
    .decTap     (decTap),
    .rdData     (rdData),
    .eccStatus  (eccStatus)
  );

endmodule

// File: rtl/ecc_sdp_chk.sv
module ecc_sdp_chk #(
  parameter bit OUT_REG    = 1'b1,
  parameter bit STATUS_REG = 1'b1
) (
  input logic        rdClk,
  input logic        outAclr,
  input logic [63:0] rdData,
  input logic [2:0]  eccStatus,
  input logic [63:0] decTap
);

  // R4
  legal_status_chk: assert property (@(posedge rdClk) disable iff (outAclr)
    (eccStatus == 3'b000 || eccStatus == 3'b011 || eccStatus == 3'b101));

  // R6
  clear_zero_data_chk: assert property (@(posedge rdClk)
    outAclr |-> rdData == 64'd0);

  generate
    if (STATUS_REG) begin : g_stChk
      // R7
      clear_zero_status_chk: assert property (@(posedge rdClk)
        outAclr |-> eccStatus == 3'b000);
    end
    if (OUT_REG) begin : g_latChk
      // R5
      reg_latency_chk: assert property (@(posedge rdClk) disable iff (outAclr)
        !outAclr |=> rdData == $past(decTap));
    end
  endgenerate

endmodule

bind ecc_sdp_ram ecc_sdp_chk #(
  .OUT_REG    (OUT_REG),
  .STATUS_REG (STATUS_REG)
) u_chk (
  .rdClk     (rdClk),
  .outAclr   (outAclr),
  .rdData    (rdData),
  .eccStatus (eccStatus),
  .decTap    (decTap)
);

// File: tb/ecc_sdp_ram_tb.sv
`timescale 1ns/1ps
module ecc_sdp_ram_tb;

  localparam int AW = 4;
  localparam int NWORDS = 1 << AW;

  logic        clk = 1'b0;
  logic        wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [71:0] wrFlipMask = '0;
  logic [AW-1:0] rdAddr = '0;
  logic        outAclr = 1'b1;

  logic [63:0] dataReg, dataByp;
  logic [2:0]  statReg, statByp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_sdp_ram #(.ADDR_W(AW), .OUT_REG(1'b1), .STATUS_REG(1'b1)) u_dut (
    .wrClk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrFlipMask(wrFlipMask), .rdClk(clk), .rdAddr(rdAddr),
    .outAclr(outAclr), .rdData(dataReg), .eccStatus(statReg));

  ecc_sdp_ram #(.ADDR_W(AW), .OUT_REG(1'b0), .STATUS_REG(1'b0)) u_dutByp (
    .wrClk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrFlipMask(wrFlipMask), .rdClk(clk), .rdAddr(rdAddr),
    .outAclr(outAclr), .rdData(dataByp), .eccStatus(statByp));

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s data act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s status act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chkLegal(input string req, input logic [2:0] act);
    total++;
    if (!(act == 3'b000 || act == 3'b011 || act == 3'b101)) begin
      bad++;
      $display("FAIL %s status act=%b exp=000/011/101", req, act);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic doWrite(input logic [AW-1:0] a, input logic [63:0] d,
                         input logic [71:0] m, input logic en);
    wrEn = en; wrAddr = a; wrData = d; wrFlipMask = m;
    @(negedge clk);
    wrEn = 1'b0; wrFlipMask = '0;
  endtask

  task automatic doRead(input logic [AW-1:0] a,
                        output logic [63:0] bd, output logic [2:0] bs,
                        output logic [63:0] rd, output logic [2:0] rs);
    rdAddr = a;
    @(negedge clk);
    bd = dataByp; bs = statByp;
    @(negedge clk);
    rd = dataReg; rs = statReg;
  endtask

  function automatic logic [63:0] pattern(input int k);
    return (64'(k) + 64'd1) * 64'h9E37_79B9_7F4A_7C15 ^ {32'(k), 32'hA5A5_0F0F};
  endfunction

  initial begin
    logic [63:0] bd, rd, expD, oldD;
    logic [2:0]  bs, rs;

    repeat (3) @(negedge clk);
    // R6 R7: clear held from time zero
    chk64("R6 reg", dataReg, 64'd0);
    chk64("R6 byp", dataByp, 64'd0);
    chk3("R7 reg", statReg, 3'b000);
    outAclr = 1'b0;
    @(negedge clk);

    // R1: every address, two data patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < NWORDS; a++)
        doWrite(AW'(a), pass == 0 ? pattern(a) : ~pattern(a + 40), 72'd0, 1'b1);
      for (int a = 0; a < NWORDS; a++) begin
        expD = pass == 0 ? pattern(a) : ~pattern(a + 40);
        doRead(AW'(a), bd, bs, rd, rs);
        chk64("R1 byp", bd, expD); chk3("R1 byp", bs, 3'b000);
        chk64("R1 reg", rd, expD); chk3("R1 reg", rs, 3'b000);
      end
    end

    // R5: latency, bypass valid after one edge, registered still old
    doWrite(4'd1, 64'h1111_2222_3333_4444, 72'd0, 1'b1);
    doWrite(4'd2, 64'hDEAD_BEEF_0BAD_F00D, 72'd0, 1'b1);
    rdAddr = 4'd1;
    @(negedge clk); @(negedge clk);
    rdAddr = 4'd2;
    @(negedge clk);
    chk64("R5 byp one edge", dataByp, 64'hDEAD_BEEF_0BAD_F00D);
    chk64("R5 reg lags", dataReg, 64'h1111_2222_3333_4444);
    @(negedge clk);
    chk64("R5 reg two edges", dataReg, 64'hDEAD_BEEF_0BAD_F00D);

    // R2: single fault at each codeword position
    for (int b = 0; b < 72; b++) begin
      expD = pattern(b + 100);
      doWrite(AW'(b), expD, 72'd1 << b, 1'b1);
      doRead(AW'(b), bd, bs, rd, rs);
      chk64("R2 byp", bd, expD); chk3("R2 byp", bs, 3'b011);
      chk64("R2 reg", rd, expD); chk3("R2 reg", rs, 3'b011);
    end

    // R3: every pair of faults
    for (int i = 0; i < 72; i++) begin
      for (int j = i + 1; j < 72; j++) begin
        doWrite(AW'(i + j), pattern(i * 72 + j), (72'd1 << i) | (72'd1 << j), 1'b1);
        doRead(AW'(i + j), bd, bs, rd, rs);
        chk3("R3 byp", bs, 3'b101);
        chk3("R3 reg", rs, 3'b101);
      end
    end

    // R4: three faults give only legal codes
    for (int i = 0; i < 60; i++) begin
      doWrite(AW'(i), pattern(i + 7), (72'd7 << i), 1'b1);
      doRead(AW'(i), bd, bs, rd, rs);
      chkLegal("R4 byp", bs);
      chkLegal("R4 reg", rs);
    end

    // R10: disabled write leaves word untouched
    doWrite(4'd5, 64'hCAFE_0000_1234_5678, 72'd0, 1'b1);
    doWrite(4'd5, 64'h0, 72'hFF_FFFF_FFFF_FFFF_FFFF, 1'b0);
    doRead(4'd5, bd, bs, rd, rs);
    chk64("R10 byp", bd, 64'hCAFE_0000_1234_5678); chk3("R10 byp", bs, 3'b000);
    chk64("R10 reg", rd, 64'hCAFE_0000_1234_5678); chk3("R10 reg", rs, 3'b000);

    // R9: read on the write edge returns old content
    oldD = 64'hCAFE_0000_1234_5678;
    rdAddr = 4'd5;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd5; wrData = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    wrEn = 1'b0;
    chk64("R9 old", dataByp, oldD);
    @(negedge clk);
    chk64("R9 new", dataByp, 64'h5555_AAAA_5555_AAAA);

    // R6 R7 R8: clear while a corrected word is on the outputs
    doWrite(4'd9, 64'h0F0F_F0F0_1234_4321, 72'd1 << 30, 1'b1);
    doRead(4'd9, bd, bs, rd, rs);
    chk3("R2 pre-clear", statByp, 3'b011);
    #1 outAclr = 1'b1;
    #0.5;
    chk64("R6 reg async", dataReg, 64'd0);
    chk64("R6 byp async", dataByp, 64'd0);
    chk3("R7 reg async", statReg, 3'b000);
    chk3("R8 byp status kept", statByp, 3'b011);
    @(negedge clk);
    outAclr = 1'b0;
    #0.5;
    chk64("R6 byp held after release", dataByp, 64'd0);
    @(negedge clk);
    chk64("R6 byp restored", dataByp, 64'h0F0F_F0F0_1234_4321);
    chk64("R6 reg restored", dataReg, 64'h0F0F_F0F0_1234_4321);
    chk3("R7 reg restored", statReg, 3'b011);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule